// File: doc/BRIEF.md
# Satellite Control Tone Envelope Transmitter

This block generates the keying envelope for the 22 kHz signalling tone that a satellite receiver uses to control dish-side equipment. It has a single output bit. A separate carrier generator gates its tone with that bit. The message bytes are written into a small register file over a byte-wide load port. The caller then sets a length and a burst selector and pulses `start`. The block holds the line silent for a lead guard and sends each byte in pulse-width code, with an odd parity bit after each byte. It then keeps a trailing guard and, if selected, adds a tone burst and a closing quiet gap. `busy` covers the whole sequence. `done` pulses once when the sequence ends.

All durations are counted in pulses of a one-cycle microsecond enable, `us_tick`, and every duration is a parameter. When no command is running, the output follows the continuous-tone enable, so the same wire also carries the plain band-select tone.

Top module: `sat_ctl_tx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tone_gate`, `busy` and `done` are 0.
- R2: While idle, `tone_gate` takes the value of `tone_en` one clock edge later. While a command is running, `tone_en` has no effect on the envelope.
- R3: A `start` seen while idle is accepted, and `busy` is 1 after that same edge. The line is then low for GUARD_TICKS ticks. The registered length is `msg_len`, clamped to MAX_BYTES.
- R4: A 1 bit is ONE_HI_TICKS of tone followed by BIT_TICKS minus ONE_HI_TICKS of silence. A 0 bit is ZERO_HI_TICKS of tone followed by the rest of BIT_TICKS in silence.
- R5: Bytes are taken from register-file addresses 0 upward. Each byte is sent bit 7 first, then a parity bit chosen so that the nine bits hold an odd number of ones.
- R6: After the last message byte the line is low for GUARD_TICKS ticks.
- R7: With `burst_sel` = 1 (burst A), the trailing guard is followed by TONE_A_TICKS of unbroken tone, then QUIET_TICKS of silence.
- R8: With `burst_sel` = 2 (burst B), the trailing guard is followed by byte 0xFF coded as in R4 and R5 (parity bit 1), then QUIET_TICKS of silence.
- R9: With `burst_sel` = 0 or 3 (no burst), the command ends right after the trailing guard and no quiet gap is added.
- R10: With a length of zero, the lead and trailing guards run back to back (2 x GUARD_TICKS low), followed by the selected burst, if any.
- R11: `done` is high for exactly one cycle: the first cycle in which `busy` is low again after a command.
- R12: A `start` while `busy` is ignored. The running envelope, the registered length and the burst selection are unchanged.
- R13: Durations advance only on cycles with `us_tick` high. A segment of D ticks lasts exactly D tick periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle timing enable, one per microsecond |
| wr_en | input | 1 | Write strobe for the message register file |
| wr_addr | input | AW | Byte address for the write |
| wr_byte | input | 8 | Byte to store |
| msg_len | input | LW | Number of message bytes, sampled at start |
| burst_sel | input | 2 | 0/3 no burst, 1 burst A, 2 burst B; sampled at start |
| tone_en | input | 1 | Continuous tone request while idle |
| start | input | 1 | Begin a command (one-cycle strobe) |
| tone_gate | output | 1 | Registered envelope: 1 = tone on |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
`busy` is due at the clock edge that samples `start`, and the line goes low at that same edge. Each later segment changes at the edge of its last counted tick. With `us_tick` held high, a segment of D ticks therefore shows as D cycles of constant `tone_gate`, and `done` comes up in the first cycle after `busy` drops. The bench samples every output on the falling edge. It measures each run of equal level while `busy` is high and compares the run against a queue of expected level/length pairs. Neighbouring runs of the same level are merged before the compare. For the slow-tick case, `start` is issued in a cycle that carries a tick, so every segment is exactly three cycles per tick.

// File: rtl/sat_ctl_pkg.sv
package sat_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_DATA,
    PH_TRAIL,
    PH_TONE_A,
    PH_CODED_B,
    PH_QUIET
  } phase_e;

  localparam logic [1:0] SEL_TONE_A  = 2'd1;
  localparam logic [1:0] SEL_CODED_B = 2'd2;

  // odd parity over data plus parity bit: accumulator seeded with 1
  function automatic logic odd_fill(input logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/sat_ctl_msgbuf.sv
module sat_ctl_msgbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [7:0]            wdata,
  output logic [DEPTH-1:0][7:0] bytes_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_rd
    assign bytes_o[g] = mem[g];
  end
endmodule

// File: rtl/sat_ctl_interval.sv
module sat_ctl_interval #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] rem_q;

  assign expire = tick && (rem_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)                         rem_q <= '0;
    else if (load)                   rem_q <= load_val;
    else if (tick && rem_q != '0)    rem_q <= rem_q - CW'(1);
  end

  // R13
  seg_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> rem_q == $past(load_val));
  // R13
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(rem_q));
endmodule

// File: rtl/sat_ctl_tx.sv
module sat_ctl_tx
  import sat_ctl_pkg::*;
#(
  parameter int MAX_BYTES     = 4,
  parameter int ONE_HI_TICKS  = 500,
  parameter int ZERO_HI_TICKS = 1000,
  parameter int BIT_TICKS     = 1500,
  parameter int GUARD_TICKS   = 16000,
  parameter int TONE_A_TICKS  = 12500,
  parameter int QUIET_TICKS   = 20000,
  localparam int AW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int LW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          us_tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_byte,
  input  logic [LW-1:0] msg_len,
  input  logic [1:0]    burst_sel,
  input  logic          tone_en,
  input  logic          start,
  output logic          tone_gate,
  output logic          busy,
  output logic          done
);
  localparam int L1 = (GUARD_TICKS > QUIET_TICKS) ? GUARD_TICKS : QUIET_TICKS;
  localparam int L2 = (L1 > TONE_A_TICKS) ? L1 : TONE_A_TICKS;
  localparam int L3 = (L2 > BIT_TICKS) ? L2 : BIT_TICKS;
  localparam int CW = $clog2(L3 + 1);

  logic [MAX_BYTES-1:0][7:0] bytes;
  phase_e        phase_q, n_phase;
  logic [LW-1:0] len_q, byte_q, n_byte;
  logic [1:0]    burst_q;
  logic [3:0]    bit_q, n_bit;
  logic          half_q, n_half, gate_q, n_gate, done_q;
  logic          ld, expire, fin, accept;
  logic [CW-1:0] ld_val;
  logic [7:0]    cur_byte, next_byte;
  logic          more_bytes;

  sat_ctl_msgbuf #(.DEPTH(MAX_BYTES), .AW(AW)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_byte), .bytes_o(bytes));

  sat_ctl_interval #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .tick(us_tick), .load(ld), .load_val(ld_val),
    .expire(expire));

  function automatic logic bit_at(input logic [7:0] b, input logic [3:0] idx);
    return (idx == 4'd8) ? odd_fill(b) : b[3'(4'd7 - idx)];
  endfunction

  function automatic logic [CW-1:0] hi_len(input logic v);
    return v ? CW'(ONE_HI_TICKS) : CW'(ZERO_HI_TICKS);
  endfunction

  assign cur_byte   = (phase_q == PH_CODED_B) ? 8'hFF : bytes[AW'(byte_q)];
  assign more_bytes = (phase_q == PH_DATA) && ((byte_q + LW'(1)) < len_q);
  assign next_byte  = bytes[AW'(byte_q + LW'(1))];

  always_comb begin
    n_phase = phase_q; n_byte = byte_q; n_bit = bit_q; n_half = half_q;
    n_gate = gate_q; ld = 1'b0; ld_val = '0; fin = 1'b0; accept = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        n_gate = tone_en;
        if (start) begin
          accept = 1'b1; n_phase = PH_LEAD; n_gate = 1'b0;
          ld = 1'b1; ld_val = CW'(GUARD_TICKS);
        end
      end
      PH_LEAD: if (expire) begin
        ld = 1'b1;
        if (len_q != '0) begin
          n_phase = PH_DATA; n_byte = '0; n_bit = '0; n_half = 1'b0;
          n_gate = 1'b1; ld_val = hi_len(bytes[0][7]);
        end else begin
          n_phase = PH_TRAIL; ld_val = CW'(GUARD_TICKS);
        end
      end
      PH_DATA, PH_CODED_B: if (expire) begin
        ld = 1'b1;
        if (!half_q) begin
          n_half = 1'b1; n_gate = 1'b0;
          ld_val = CW'(BIT_TICKS) - hi_len(bit_at(cur_byte, bit_q));
        end else if (bit_q != 4'd8) begin
          n_bit = bit_q + 4'd1; n_half = 1'b0; n_gate = 1'b1;
          ld_val = hi_len(bit_at(cur_byte, bit_q + 4'd1));
        end else if (more_bytes) begin
          n_byte = byte_q + LW'(1); n_bit = '0; n_half = 1'b0; n_gate = 1'b1;
          ld_val = hi_len(next_byte[7]);
        end else if (phase_q == PH_DATA) begin
          n_phase = PH_TRAIL; ld_val = CW'(GUARD_TICKS);
        end else begin
          n_phase = PH_QUIET; ld_val = CW'(QUIET_TICKS);
        end
      end
      PH_TRAIL: if (expire) begin
        if (burst_q == SEL_TONE_A) begin
          n_phase = PH_TONE_A; n_gate = 1'b1; ld = 1'b1;
          ld_val = CW'(TONE_A_TICKS);
        end else if (burst_q == SEL_CODED_B) begin
          n_phase = PH_CODED_B; n_bit = '0; n_half = 1'b0; n_gate = 1'b1;
          ld = 1'b1; ld_val = hi_len(1'b1);
        end else begin
          fin = 1'b1;
        end
      end
      PH_TONE_A: if (expire) begin
        n_phase = PH_QUIET; n_gate = 1'b0; ld = 1'b1;
        ld_val = CW'(QUIET_TICKS);
      end
      PH_QUIET: if (expire) fin = 1'b1;
      default: fin = 1'b1;
    endcase
    if (fin) begin
      n_phase = PH_IDLE; n_gate = tone_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE; len_q <= '0; burst_q <= '0; byte_q <= '0;
      bit_q <= '0; half_q <= 1'b0; gate_q <= 1'b0; done_q <= 1'b0;
    end else begin
      phase_q <= n_phase; byte_q <= n_byte; bit_q <= n_bit;
      half_q <= n_half; gate_q <= n_gate; done_q <= fin;
      if (accept) begin
        len_q   <= (msg_len > LW'(MAX_BYTES)) ? LW'(MAX_BYTES) : msg_len;
        burst_q <= burst_sel;
      end
    end
  end

  assign tone_gate = gate_q;
  assign busy      = (phase_q != PH_IDLE);
  assign done      = done_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(len_q) && $stable(burst_q)));
  // R3
  lead_low_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LEAD) |-> !tone_gate);
  // R6
  silent_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_TRAIL || phase_q == PH_QUIET) |-> !tone_gate);
  // R4
  bit_tone_chk: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_DATA || phase_q == PH_CODED_B) && !half_q) |-> tone_gate);
  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> (tone_gate == $past(tone_en)));
endmodule

// File: tb/sat_ctl_tx_tb.sv
module sat_ctl_tx_tb;
  localparam int ONE = 10, ZERO = 20, BITT = 30, GRD = 320, TA = 250, QT = 400;

  typedef struct { logic lvl; int len; } seg_t;

  logic clk = 0, rst = 1, wr_en = 0, tone_en = 0, start = 0, slow = 0;
  logic [1:0] wr_addr = 0, burst_sel = 0;
  logic [7:0] wr_byte = 0;
  logic [2:0] msg_len = 0;
  logic us_tick, tone_gate, busy, done;
  int cyc = 0, checks = 0, fails = 0;
  logic [7:0] ref_mem [4];
  seg_t exp_q [$];
  string cur_req = "R1";

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign us_tick = slow ? (cyc % 3 == 0) : 1'b1;

  sat_ctl_tx #(.MAX_BYTES(4), .ONE_HI_TICKS(ONE), .ZERO_HI_TICKS(ZERO),
    .BIT_TICKS(BITT), .GUARD_TICKS(GRD), .TONE_A_TICKS(TA), .QUIET_TICKS(QT)) u_dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_byte(wr_byte), .msg_len(msg_len), .burst_sel(burst_sel), .tone_en(tone_en),
    .start(start), .tone_gate(tone_gate), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic lvl, input int len);
    seg_t t;
    if (exp_q.size() > 0 && exp_q[exp_q.size()-1].lvl == lvl) begin
      t = exp_q.pop_back(); t.len += len; exp_q.push_back(t);
    end else begin
      t.lvl = lvl; t.len = len; exp_q.push_back(t);
    end
  endtask

  task automatic push_bit(input logic v, input int sc);
    int hi = v ? ONE : ZERO;
    push(1'b1, hi * sc);
    push(1'b0, (BITT - hi) * sc);
  endtask

  task automatic push_byte(input logic [7:0] b, input int sc);
    int ones = 0;
    for (int i = 7; i >= 0; i--) begin
      push_bit(b[i], sc);
      ones += b[i];
    end
    push_bit((ones % 2) == 0, sc);
  endtask

  // scoreboard monitor: run-length encode tone_gate while busy
  initial begin
    bit active = 0;
    logic run_lvl = 0;
    int run_len = 0;
    seg_t e;
    forever begin
      @(negedge clk);
      if (busy) begin
        if (!active) begin
          active = 1; run_lvl = tone_gate; run_len = 1;
        end else if (tone_gate == run_lvl) begin
          run_len++;
        end else begin
          if (exp_q.size() == 0) chk(0, cur_req, run_len, 0);
          else begin
            e = exp_q.pop_front();
            chk(e.lvl == run_lvl && e.len == run_len, cur_req, run_len, e.len);
          end
          run_lvl = tone_gate; run_len = 1;
        end
      end else if (active) begin
        active = 0;
        if (exp_q.size() == 0) chk(0, cur_req, run_len, 0);
        else begin
          e = exp_q.pop_front();
          chk(e.lvl == run_lvl && e.len == run_len, cur_req, run_len, e.len);
        end
        chk(done == 1'b1, "R11 done with busy fall", done, 1);
        chk(exp_q.size() == 0, {cur_req, " leftover segments"}, exp_q.size(), 0);
        exp_q.delete();
      end
    end
  end

  task automatic load(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'(a); wr_byte = d; ref_mem[a] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_cmd(input int len, input logic [1:0] bsel, input int sc,
                         input bit intrude, input string req);
    int nb = (len > 4) ? 4 : len;
    int n = 0;
    cur_req = req;
    push(1'b0, GRD * sc);
    for (int i = 0; i < nb; i++) push_byte(ref_mem[i], sc);
    push(1'b0, GRD * sc);
    if (bsel == 2'd1) begin push(1'b1, TA * sc); push(1'b0, QT * sc); end
    else if (bsel == 2'd2) begin push_byte(8'hFF, sc); push(1'b0, QT * sc); end
    msg_len = 3'(len); burst_sel = bsel;
    if (sc > 1) begin
      do @(negedge clk); while (!us_tick);
    end else @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    while (busy) begin
      @(negedge clk); n++;
      if (intrude && n == 40) begin
        msg_len = 3'd1; burst_sel = 2'd2; start = 1;
        @(negedge clk);
        start = 0; n++;
        chk(busy == 1'b1, "R12 still busy after ignored start", busy, 1);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tone_gate == 0 && busy == 0 && done == 0, "R1 reset outputs", tone_gate, 0);
    rst = 0;
    @(negedge clk);
    chk(tone_gate == 0 && busy == 0 && done == 0, "R1 after reset", busy, 0);
    tone_en = 1;
    @(negedge clk);
    chk(tone_gate == 1'b1, "R2 idle follows tone_en high", tone_gate, 1);
    tone_en = 0;
    @(negedge clk);
    chk(tone_gate == 1'b0, "R2 idle follows tone_en low", tone_gate, 0);

    load(0, 8'hA5);
    run_cmd(1, 2'd0, 1, 0, "R3/R4/R5/R6/R9 one byte no burst");

    load(0, 8'hE2); load(1, 8'h00); load(2, 8'h7F);
    tone_en = 1;
    run_cmd(3, 2'd1, 1, 0, "R2/R5/R7 three bytes burst A");
    chk(tone_gate == 1'b1, "R2 tone restored after command", tone_gate, 1);
    tone_en = 0;
    @(negedge clk);

    load(0, 8'h3C); load(1, 8'h81);
    run_cmd(2, 2'd2, 1, 0, "R8 two bytes burst B");

    run_cmd(0, 2'd1, 1, 0, "R10 empty burst A");
    run_cmd(0, 2'd2, 1, 0, "R10 empty burst B");

    load(0, 8'h11); load(1, 8'h22); load(2, 8'h33); load(3, 8'h44);
    run_cmd(6, 2'd3, 1, 0, "R3/R9 clamped length, selector 3");

    load(0, 8'hC3);
    run_cmd(1, 2'd1, 1, 1, "R12 start while busy");

    load(0, 8'h5A);
    slow = 1;
    run_cmd(1, 2'd2, 3, 0, "R13 tick every third cycle");
    slow = 0;

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule